// File: doc/BRIEF.md
# Bidirectional Cross-Clock Mailbox Pair

This block gives two ports, each running on its own free-running clock, a side channel for single-word messages that does not pass through the main queue. There are two independent one-word mailboxes. One carries a word from port A to port B, and the other carries a word from port B to port A. Each mailbox is written by one side and read by the other. The two port clocks may be unrelated, and either may run faster.

A port reaches the mailboxes only when its chip select, its enable and its mailbox-select input are all high on the rising edge of its clock. The write/read input then picks the operation. A write to an empty mailbox stores the word and marks the mailbox as occupied on the sender's side. The occupied state reaches the receiver through a two-flop synchronizer, where it appears as an active-low mail-present output. When the receiver reads the word, a toggle travels back through a second synchronizer and frees the mailbox for the sender. A write attempted while the mailbox is still occupied has no effect, so a word that has not been read is never lost.

Reset is synchronous and active high. It is sampled in each clock domain and returns both mailboxes, both handshakes and both read outputs to zero.

Top module: `mbx_pair`

## Requirements
- R1: There are two independent mailboxes of DATA_W bits (default 36), one for A to B and one for B to A. Every bit of a written word arrives unchanged at the other port.
- R2: A port acts on a mailbox only when its cs, en and mbsel inputs are all 1 on its rising clock edge. wr=1 then means write and wr=0 means read. With any of the three inputs at 0, nothing changes.
- R3: A write to an empty mailbox stores the word. A write while the mailbox still holds unread mail is ignored, and the word that was first stored is the one that is delivered.
- R4: The receiver's active-low mail output (mail_n_b for A to B, mail_n_a for B to A) goes to 0 after the second receiver clock edge that follows the accepting write edge. It stays at 0 until the mail is read.
- R5: A read while mail is present puts the stored word on the receiver's dout after that edge and returns the mail output to 1 after the same edge.
- R6: A read while no mail is present leaves dout and the mail output unchanged.
- R7: After a read, the sender's mailbox stays occupied until the read has passed through two sender clock edges. A write on the following sender edge is accepted.
- R8: Reset held for at least three cycles of each clock clears both stored words, drives both dout outputs to 0 and drives both mail outputs to 1.
- R9: dout changes only on an accepted read. Between accepted reads it holds its value.
- R10: Both directions may carry traffic at the same time without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset, sampled by both clocks |
| clk_a | input | 1 | Port A clock |
| cs_a | input | 1 | Port A chip select, active high |
| en_a | input | 1 | Port A enable, active high |
| wr_a | input | 1 | Port A direction: 1 write, 0 read |
| mbsel_a | input | 1 | Port A mailbox select, active high |
| din_a | input | DATA_W | Word written into the A-to-B mailbox |
| dout_a | output | DATA_W | Last word read from the B-to-A mailbox |
| mail_n_a | output | 1 | Low while B-to-A mail waits for port A |
| clk_b | input | 1 | Port B clock |
| cs_b | input | 1 | Port B chip select, active high |
| en_b | input | 1 | Port B enable, active high |
| wr_b | input | 1 | Port B direction: 1 write, 0 read |
| mbsel_b | input | 1 | Port B mailbox select, active high |
| din_b | input | DATA_W | Word written into the B-to-A mailbox |
| dout_b | output | DATA_W | Last word read from the A-to-B mailbox |
| mail_n_b | output | 1 | Low while A-to-B mail waits for port B |

## Verification
The bench runs both clocks at the same rate with a fixed phase offset, so that every synchronizer latency can be predicted to the exact cycle. It first tries single transfers with one control input at 0 at a time, to tell a decoded access from a stray one. It then tries back-to-back writes, which separate an ignored overwrite from a lost word, and reads with no mail waiting, which separate a real capture from a spurious one. A flood of writes on every cycle around a read pins down the earliest cycle at which the sender is freed. Random traffic in both directions at once, with random select and enable patterns, exposes any coupling between the two channels.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Decoded access request of one port for the current clock edge.
    typedef struct packed {
        logic wr;
        logic rd;
    } mbx_req_t;

    // Smallest synchronizer depth that keeps metastability settled.
    localparam int MBX_MIN_STAGES = 2;

    function automatic mbx_req_t mbx_decode(
        input logic cs,
        input logic en,
        input logic sel,
        input logic wr
    );
        mbx_req_t r;
        logic     hit;
        hit  = cs & en & sel;
        r.wr = hit & wr;
        r.rd = hit & ~wr;
        return r;
    endfunction

endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int N = (STAGES < mbx_pkg::MBX_MIN_STAGES) ? mbx_pkg::MBX_MIN_STAGES : STAGES;

    logic [N-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[N-2:0], d};
        end
    end

    assign q = chain[N-1];
endmodule

// File: rtl/mbx_port_ctl.sv
module mbx_port_ctl
    import mbx_pkg::*;
(
    input  logic     cs,
    input  logic     en,
    input  logic     sel,
    input  logic     wr,
    output mbx_req_t req
);
    always_comb begin
        req = mbx_decode(cs, en, sel, wr);
    end
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
    parameter int W      = 36,
    parameter int STAGES = 2
) (
    input  logic         rst,
    // sender domain
    input  logic         clk_s,
    input  logic         wr_s,
    input  logic [W-1:0] din_s,
    output logic         full_s,
    output logic [W-1:0] store,
    // receiver domain
    input  logic         clk_r,
    input  logic         rd_r,
    output logic [W-1:0] dout_r,
    output logic         avail_r
);
    logic put_tog;
    logic ack_tog;
    logic put_seen;
    logic ack_seen;

    // Sender: accept a word only while the mailbox is free.
    always_ff @(posedge clk_s) begin
        if (rst) begin
            put_tog <= 1'b0;
            store   <= '0;
        end else if (wr_s && !full_s) begin
            put_tog <= ~put_tog;
            store   <= din_s;
        end
    end

    mbx_sync #(.STAGES(STAGES)) u_put_sync (
        .clk (clk_r),
        .rst (rst),
        .d   (put_tog),
        .q   (put_seen)
    );

    mbx_sync #(.STAGES(STAGES)) u_ack_sync (
        .clk (clk_s),
        .rst (rst),
        .d   (ack_tog),
        .q   (ack_seen)
    );

    assign full_s  = put_tog ^ ack_seen;
    assign avail_r = put_seen ^ ack_tog;

    // Receiver: capture the word and hand the slot back.
    always_ff @(posedge clk_r) begin
        if (rst) begin
            ack_tog <= 1'b0;
            dout_r  <= '0;
        end else if (rd_r && avail_r) begin
            ack_tog <= ~ack_tog;
            dout_r  <= store;
        end
    end
endmodule

// File: rtl/mbx_pair.sv
module mbx_pair
    import mbx_pkg::*;
#(
    parameter int DATA_W      = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic              rst,
    input  logic              clk_a,
    input  logic              cs_a,
    input  logic              en_a,
    input  logic              wr_a,
    input  logic              mbsel_a,
    input  logic [DATA_W-1:0] din_a,
    output logic [DATA_W-1:0] dout_a,
    output logic              mail_n_a,
    input  logic              clk_b,
    input  logic              cs_b,
    input  logic              en_b,
    input  logic              wr_b,
    input  logic              mbsel_b,
    input  logic [DATA_W-1:0] din_b,
    output logic [DATA_W-1:0] dout_b,
    output logic              mail_n_b
);
    localparam int NPORT = 2;   // index 0 = port A, 1 = port B

    logic [NPORT-1:0] clk_v, cs_v, en_v, wr_v, sel_v;
    logic [DATA_W-1:0] din_v   [NPORT];
    logic [DATA_W-1:0] dout_v  [NPORT];   // indexed by receiving port
    logic [DATA_W-1:0] store_v [NPORT];   // indexed by sending port
    logic [NPORT-1:0]  avail_v;           // indexed by receiving port
    logic [NPORT-1:0]  full_v;            // indexed by sending port
    mbx_req_t          req_v   [NPORT];

    assign clk_v = {clk_b,   clk_a};
    assign cs_v  = {cs_b,    cs_a};
    assign en_v  = {en_b,    en_a};
    assign wr_v  = {wr_b,    wr_a};
    assign sel_v = {mbsel_b, mbsel_a};
    assign din_v[0] = din_a;
    assign din_v[1] = din_b;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        mbx_port_ctl u_ctl (
            .cs  (cs_v[p]),
            .en  (en_v[p]),
            .sel (sel_v[p]),
            .wr  (wr_v[p]),
            .req (req_v[p])
        );
    end

    // Channel d carries words from port d to port 1-d.
    for (genvar d = 0; d < NPORT; d++) begin : g_chan
        mbx_channel #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_chan (
            .rst     (rst),
            .clk_s   (clk_v[d]),
            .wr_s    (req_v[d].wr),
            .din_s   (din_v[d]),
            .full_s  (full_v[d]),
            .store   (store_v[d]),
            .clk_r   (clk_v[NPORT-1-d]),
            .rd_r    (req_v[NPORT-1-d].rd),
            .dout_r  (dout_v[NPORT-1-d]),
            .avail_r (avail_v[NPORT-1-d])
        );
    end

    assign dout_a   = dout_v[0];
    assign dout_b   = dout_v[1];
    assign mail_n_a = ~avail_v[0];
    assign mail_n_b = ~avail_v[1];
endmodule

// File: rtl/mbx_pair_chk.sv
module mbx_pair_chk #(
    parameter int W = 36
) (
    input logic         rst,
    input logic         clk_a,
    input logic         cs_a,
    input logic         en_a,
    input logic         wr_a,
    input logic         mbsel_a,
    input logic [W-1:0] dout_a,
    input logic         mail_n_a,
    input logic         clk_b,
    input logic         cs_b,
    input logic         en_b,
    input logic         wr_b,
    input logic         mbsel_b,
    input logic [W-1:0] dout_b,
    input logic         mail_n_b,
    input logic         full_ab,
    input logic         full_ba,
    input logic [W-1:0] store_ab,
    input logic [W-1:0] store_ba
);
    logic rd_a, rd_b;
    assign rd_a = cs_a & en_a & mbsel_a & ~wr_a;
    assign rd_b = cs_b & en_b & mbsel_b & ~wr_b;

    p_hold_unread_ab_r3: assert property (@(posedge clk_a) disable iff (rst)
        full_ab |=> $stable(store_ab));
    p_hold_unread_ba_r3: assert property (@(posedge clk_b) disable iff (rst)
        full_ba |=> $stable(store_ba));

    p_mail_persist_b_r4: assert property (@(posedge clk_b) disable iff (rst)
        (!mail_n_b && !rd_b) |=> !mail_n_b);
    p_mail_persist_a_r4: assert property (@(posedge clk_a) disable iff (rst)
        (!mail_n_a && !rd_a) |=> !mail_n_a);

    p_read_clears_b_r5: assert property (@(posedge clk_b) disable iff (rst)
        (!mail_n_b && rd_b) |=> mail_n_b);
    p_read_clears_a_r5: assert property (@(posedge clk_a) disable iff (rst)
        (!mail_n_a && rd_a) |=> mail_n_a);

    p_empty_read_b_r6: assert property (@(posedge clk_b) disable iff (rst)
        (mail_n_b && rd_b) |=> $stable(dout_b));
    p_empty_read_a_r6: assert property (@(posedge clk_a) disable iff (rst)
        (mail_n_a && rd_a) |=> $stable(dout_a));

    p_dout_hold_b_r9: assert property (@(posedge clk_b) disable iff (rst)
        !rd_b |=> $stable(dout_b));
    p_dout_hold_a_r9: assert property (@(posedge clk_a) disable iff (rst)
        !rd_a |=> $stable(dout_a));

    p_reset_b_r8: assert property (@(posedge clk_b)
        rst |=> (mail_n_b && dout_b == '0));
    p_reset_a_r8: assert property (@(posedge clk_a)
        rst |=> (mail_n_a && dout_a == '0));
endmodule

bind mbx_pair mbx_pair_chk #(.W(DATA_W)) u_chk (
    .rst      (rst),
    .clk_a    (clk_a),
    .cs_a     (cs_a),
    .en_a     (en_a),
    .wr_a     (wr_a),
    .mbsel_a  (mbsel_a),
    .dout_a   (dout_a),
    .mail_n_a (mail_n_a),
    .clk_b    (clk_b),
    .cs_b     (cs_b),
    .en_b     (en_b),
    .wr_b     (wr_b),
    .mbsel_b  (mbsel_b),
    .dout_b   (dout_b),
    .mail_n_b (mail_n_b),
    .full_ab  (full_v[0]),
    .full_ba  (full_v[1]),
    .store_ab (store_v[0]),
    .store_ba (store_v[1])
);

// File: tb/tb_mbx_pair.sv
`timescale 1ns/1ps
module tb_mbx_pair;
    localparam int W    = 36;
    localparam int MAXC = 2600;
    localparam int OFS  = 4;

    logic         rst;
    logic         clk_a, clk_b;
    logic         cs_a, en_a, wr_a, mbsel_a;
    logic         cs_b, en_b, wr_b, mbsel_b;
    logic [W-1:0] din_a, din_b;
    logic [W-1:0] dout_a, dout_b;
    logic         mail_n_a, mail_n_b;

    int    checks = 0;
    int    errors = 0;
    int    cyc    = 0;
    bit    done   = 0;
    string phase  = "R8";

    // Behavioural history: toggles and acks after each cycle's edge.
    bit ta [0:MAXC+OFS];
    bit ab [0:MAXC+OFS];
    bit ub [0:MAXC+OFS];
    bit aa [0:MAXC+OFS];
    logic [W-1:0] m_word_ab, m_word_ba, m_dout_a, m_dout_b;

    mbx_pair #(.DATA_W(W), .SYNC_STAGES(2)) dut (
        .rst(rst),
        .clk_a(clk_a), .cs_a(cs_a), .en_a(en_a), .wr_a(wr_a), .mbsel_a(mbsel_a),
        .din_a(din_a), .dout_a(dout_a), .mail_n_a(mail_n_a),
        .clk_b(clk_b), .cs_b(cs_b), .en_b(en_b), .wr_b(wr_b), .mbsel_b(mbsel_b),
        .din_b(din_b), .dout_b(dout_b), .mail_n_b(mail_n_b)
    );

    // 200 MHz on both ports; B rises 2 ns after A.
    initial begin
        clk_a = 0;
        forever begin
            #2.5 clk_a = 1;
            #2.5 clk_a = 0;
        end
    end
    initial begin
        clk_b = 0;
        #4.5;
        forever begin
            clk_b = 1;
            #2.5 clk_b = 0;
            #2.5;
        end
    end

    task automatic chk(string tag, string what, logic [W-1:0] got, logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h (cycle %0d)", tag, what, got, exp, cyc);
        end
    endtask

    // One cycle: inputs already set are applied at the next A and B edges,
    // then outputs are sampled 3 ns after the A edge (1 ns after the B edge).
    task automatic tick();
        bit           r, aw, ard, bw, brd;
        logic [W-1:0] ia, ib;
        int           k;
        r   = rst;
        aw  = cs_a & en_a & mbsel_a & wr_a;
        ard = cs_a & en_a & mbsel_a & ~wr_a;
        bw  = cs_b & en_b & mbsel_b & wr_b;
        brd = cs_b & en_b & mbsel_b & ~wr_b;
        ia  = din_a;
        ib  = din_b;
        @(posedge clk_a);
        #3;
        k = cyc + OFS;
        if (r) begin
            ta[k] = 0; ab[k] = 0; ub[k] = 0; aa[k] = 0;
            m_word_ab = '0; m_word_ba = '0; m_dout_a = '0; m_dout_b = '0;
        end else begin
            // A edge: write toward B, read of mail from B
            bit wa, ra, wb, rb;
            wa = aw && !(ta[k-1] ^ ab[k-3]);
            ta[k] = ta[k-1] ^ wa;
            if (wa) m_word_ab = ia;
            ra = ard && (ub[k-3] ^ aa[k-1]);
            aa[k] = aa[k-1] ^ ra;
            if (ra) m_dout_a = m_word_ba;
            // B edge: read of mail from A, write toward A
            rb = brd && (ta[k-2] ^ ab[k-1]);
            ab[k] = ab[k-1] ^ rb;
            if (rb) m_dout_b = m_word_ab;
            wb = bw && !(ub[k-1] ^ aa[k-2]);
            ub[k] = ub[k-1] ^ wb;
            if (wb) m_word_ba = ib;
        end
        chk({phase, "/R4"}, "mail_n_b", W'(mail_n_b), W'(!(ta[k-1] ^ ab[k])));
        chk({phase, "/R4"}, "mail_n_a", W'(mail_n_a), W'(!(ub[k-2] ^ aa[k])));
        chk({phase, "/R5"}, "dout_b", dout_b, m_dout_b);
        chk({phase, "/R5"}, "dout_a", dout_a, m_dout_a);
        cyc++;
    endtask

    task automatic idle();
        cs_a = 0; en_a = 0; wr_a = 0; mbsel_a = 0;
        cs_b = 0; en_b = 0; wr_b = 0; mbsel_b = 0;
    endtask
    task automatic port_a(bit c, bit e, bit w, bit s, logic [W-1:0] d);
        cs_a = c; en_a = e; wr_a = w; mbsel_a = s; din_a = d;
    endtask
    task automatic port_b(bit c, bit e, bit w, bit s, logic [W-1:0] d);
        cs_b = c; en_b = e; wr_b = w; mbsel_b = s; din_b = d;
    endtask
    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #(100000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] w1, w2, held;
        rst = 1;
        idle();
        din_a = '0; din_b = '0;

        // R8: reset state
        phase = "R8";
        run(5);
        chk("R8", "mail_n_a after reset", W'(mail_n_a), W'(1));
        chk("R8", "mail_n_b after reset", W'(mail_n_b), W'(1));
        chk("R8", "dout_a after reset", dout_a, '0);
        chk("R8", "dout_b after reset", dout_b, '0);
        rst = 0;
        run(2);

        // R2: write with one qualifier low is not a mailbox access
        phase = "R2";
        port_a(1, 1, 1, 0, 36'h1_2345_6789); tick();
        port_a(0, 1, 1, 1, 36'h2_2222_2222); tick();
        port_a(1, 0, 1, 1, 36'h3_3333_3333); tick();
        idle(); run(4);
        chk("R2", "mail_n_b after unqualified writes", W'(mail_n_b), W'(1));
        port_b(1, 1, 0, 0, '0); tick();
        idle(); run(1);
        chk("R2", "dout_b after unqualified read", dout_b, '0);

        // R3: second write while full is ignored
        phase = "R3";
        w1 = 36'hA_5A5A_0F0F;
        w2 = 36'h5_A5A5_F0F0;
        port_a(1, 1, 1, 1, w1); tick();
        port_a(1, 1, 1, 1, w2); tick();
        idle(); run(4);
        chk("R3", "mail_n_b with mail waiting", W'(mail_n_b), W'(0));
        port_b(1, 1, 0, 1, '0); tick();
        idle();
        chk("R3", "dout_b keeps first word", dout_b, w1);
        chk("R5", "mail_n_b after read", W'(mail_n_b), W'(1));

        // R6 and R9: read with no mail, then hold
        phase = "R6";
        run(4);
        held = dout_b;
        port_b(1, 1, 0, 1, '0); run(3);
        idle();
        chk("R6", "dout_b after empty reads", dout_b, held);
        phase = "R9";
        run(5);
        chk("R9", "dout_b held between reads", dout_b, held);

        // R1: full-width word in both directions
        phase = "R1";
        port_a(1, 1, 1, 1, 36'hF_FFFF_FFFF);
        port_b(1, 1, 1, 1, 36'h8_0000_0001); tick();
        idle(); run(4);
        port_a(1, 1, 0, 1, '0);
        port_b(1, 1, 0, 1, '0); tick();
        idle();
        chk("R1", "dout_b full width", dout_b, 36'hF_FFFF_FFFF);
        chk("R1", "dout_a full width", dout_a, 36'h8_0000_0001);

        // R7: writes on every cycle; model checks the earliest accepted word
        phase = "R7";
        for (int i = 0; i < 40; i++) begin
            port_a(1, 1, 1, 1, W'(36'h7_0000_0000 + i));
            if (i % 9 == 5) port_b(1, 1, 0, 1, '0); else port_b(0, 0, 0, 0, '0);
            tick();
        end
        idle(); run(4);

        // R10: both directions driven at once with random patterns
        phase = "R10";
        for (int i = 0; i < 2200; i++) begin
            logic [63:0] ra, rb;
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            port_a(($urandom % 8) != 0, ($urandom % 8) != 0, $urandom % 2,
                   ($urandom % 6) != 0, ra[W-1:0]);
            port_b(($urandom % 8) != 0, ($urandom % 8) != 0, $urandom % 2,
                   ($urandom % 6) != 0, rb[W-1:0]);
            tick();
        end
        idle(); run(6);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule